// File: doc/BRIEF.md
# Programmable Video Reference Timing Generator

This block rebuilds the reference strobes that accompany pixel data on a video output port. It counts pixel clocks along each line and lines within each frame. From those two counts and a set of programmable positions it produces an active-line window, a vertical-blanking flag, a field-identity flag, regenerated horizontal and vertical sync pulses, and a data-enable strobe. The positions are held in configuration registers elsewhere in the chip and reach this block as plain input ports.

The pixel count restarts on each rising edge of the internal horizontal sync. The line count advances on the same edge and is preset to a programmable value on the rising edge of the internal vertical sync. For interlaced input only every other vertical sync rising edge presets the line count, so the count runs across a whole frame. The vertical-blanking window, the field-switch line and the vertical sync pulse each have a separate setting for the first and the second field.

Top module: `vidref_timing`

## Requirements
- R1: While `rst` is high, the pixel and line counts are held at 0 and the field state is field one, so `fref_o` equals `fref_inv_i`. All outputs are decoded from that state.
- R2: One clock after a clock in which `hsync_i` is high and was low the clock before, the pixel count is 0. In every other clock the count goes up by 1 and wraps from 4095 to 0 (12 bits).
- R3: A rising edge of `vsync_i` that is accepted loads the line count with `line_preset_i` one clock later. This takes priority over a horizontal sync edge in the same clock. Otherwise a horizontal sync rising edge adds 1 to the line count, which wraps from 2047 to 0 (11 bits).
- R4: With `interlaced_i` low every vertical sync rising edge is accepted. With it high, edges are accepted and ignored in turn, starting with an accepted one after reset or after a rising edge seen in progressive mode. An ignored edge leaves the line count to advance normally.
- R5: `href_o` is high while the pixel count lies in [`href_start_i`, `href_stop_i`), and low otherwise.
- R6: `vref_o` is high while the line count lies in [start, start + length) for the current field: `vref1_*` for field one and `vref2_*` for field two. The sum is taken without wrap. Progressive input always uses the field-one settings.
- R7: The field state becomes field two one clock after the line count equals `fref2_line_i`. It becomes field one one clock after the line count equals `fref1_line_i`, and field two wins if both are equal. It is forced to field one one clock after any clock with `interlaced_i` low. `fref_o` is the field state (field two = 1) XOR `fref_inv_i`.
- R8: `vs_o` is high while (line, pixel) lies in the range from (vsN_line, vsN_pix) up to but not including (vsN_line + vsN_len, vsN_pix), compared line first and then pixel, using the current field's N.
- R9: `hs_o` is high while the pixel count lies in [`hs_start_i`, `hs_stop_i`).
- R10: When `href_gate_i` is 1, `href_o` is held low whenever `vref_o` is high.
- R11: `de_o` is high exactly when `href_o` is high and `vref_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Internal horizontal sync, active high |
| vsync_i | input | 1 | Internal vertical sync, active high |
| interlaced_i | input | 1 | 1 when the input is interlaced |
| line_preset_i | input | 11 | Line count loaded on an accepted vertical sync edge |
| href_start_i | input | 12 | First pixel of the active-line window |
| href_stop_i | input | 12 | First pixel after the active-line window |
| hs_start_i | input | 12 | First pixel of the regenerated horizontal sync |
| hs_stop_i | input | 12 | First pixel after the regenerated horizontal sync |
| vref1_line_i | input | 11 | First blanking line, field one |
| vref1_len_i | input | 8 | Blanking length in lines, field one |
| vref2_line_i | input | 11 | First blanking line, field two |
| vref2_len_i | input | 8 | Blanking length in lines, field two |
| fref1_line_i | input | 11 | Line at which field one begins |
| fref2_line_i | input | 11 | Line at which field two begins |
| fref_inv_i | input | 1 | Inverts the field flag |
| vs1_line_i | input | 11 | Start line of vertical sync, field one |
| vs1_pix_i | input | 12 | Start pixel of vertical sync, field one |
| vs1_len_i | input | 8 | Vertical sync length in lines, field one |
| vs2_line_i | input | 11 | Start line of vertical sync, field two |
| vs2_pix_i | input | 12 | Start pixel of vertical sync, field two |
| vs2_len_i | input | 8 | Vertical sync length in lines, field two |
| href_gate_i | input | 1 | 1 suppresses the active-line window during vertical blanking |
| href_o | output | 1 | Active-line window |
| vref_o | output | 1 | Vertical blanking flag |
| fref_o | output | 1 | Field identity flag |
| hs_o | output | 1 | Regenerated horizontal sync |
| vs_o | output | 1 | Regenerated vertical sync |
| de_o | output | 1 | Data enable |

## Verification
The hardest state to reach from the ports is the second-field vertical sync that must be ignored, together with the field switch that changes which blanking and sync windows apply. The stimulus drives interlaced frames with a vertical sync at the start of each half-frame, so every second edge must leave the line count running into the second-field line numbers. The pixel-count wrap needs a single line more than 4096 clocks long. The line-count wrap needs a preset close to 2047 followed by a run of lines with no further vertical sync. A behavioural model predicts every output in every cycle across all of these runs.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

    localparam int DEF_PIX_W  = 12;
    localparam int DEF_LINE_W = 11;
    localparam int DEF_SPAN_W = 8;

    typedef enum logic {
        FIELD_ONE = 1'b0,
        FIELD_TWO = 1'b1
    } field_e;

    typedef struct packed {
        logic hs_rise;
        logic vs_rise;
        logic preload;
    } sync_ev_t;

    // half-open window test on zero-extended positions
    function automatic logic span_hit(input logic [31:0] pos,
                                      input logic [31:0] lo,
                                      input logic [31:0] hi);
        return (pos >= lo) && (pos < hi);
    endfunction

endpackage

// File: rtl/vrt_counters.sv
module vrt_counters
    import vrt_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int LINE_W = DEF_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              interlaced_i,
    input  logic [LINE_W-1:0] line_preset_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic [LINE_W-1:0] line_o
);

    logic     hs_q;
    logic     vs_q;
    logic     skip_next;
    sync_ev_t ev;

    // edge history samples continuously so the first edge after reset is seen
    always_ff @(posedge clk) begin
        hs_q <= hsync_i;
        vs_q <= vsync_i;
    end

    always_comb begin
        ev.hs_rise = hsync_i & ~hs_q;
        ev.vs_rise = vsync_i & ~vs_q;
        ev.preload = ev.vs_rise & (~interlaced_i | ~skip_next);
    end

    // in interlaced mode every other vertical edge is the second field
    always_ff @(posedge clk) begin
        if (rst)
            skip_next <= 1'b0;
        else if (ev.vs_rise)
            skip_next <= interlaced_i ? ~skip_next : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pix_o <= '0;
        else if (ev.hs_rise)
            pix_o <= '0;
        else
            pix_o <= pix_o + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            line_o <= '0;
        else if (ev.preload)
            line_o <= line_preset_i;
        else if (ev.hs_rise)
            line_o <= line_o + 1'b1;
    end

endmodule

// File: rtl/vrt_field.sv
module vrt_field
    import vrt_pkg::*;
#(
    parameter int LINE_W = DEF_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              interlaced_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [LINE_W-1:0] f1_line_i,
    input  logic [LINE_W-1:0] f2_line_i,
    output field_e            field_o
);

    always_ff @(posedge clk) begin
        if (rst)
            field_o <= FIELD_ONE;
        else if (!interlaced_i)
            field_o <= FIELD_ONE;
        else if (line_i == f2_line_i)
            field_o <= FIELD_TWO;
        else if (line_i == f1_line_i)
            field_o <= FIELD_ONE;
    end

endmodule

// File: rtl/vrt_decode.sv
module vrt_decode
    import vrt_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int LINE_W = DEF_LINE_W,
    parameter int SPAN_W = DEF_SPAN_W
) (
    input  logic [PIX_W-1:0]             pix_i,
    input  logic [LINE_W-1:0]            line_i,
    input  field_e                       field_i,
    input  logic [PIX_W-1:0]             href_start_i,
    input  logic [PIX_W-1:0]             href_stop_i,
    input  logic [PIX_W-1:0]             hs_start_i,
    input  logic [PIX_W-1:0]             hs_stop_i,
    input  logic [1:0][LINE_W-1:0]       vref_line_i,
    input  logic [1:0][SPAN_W-1:0]       vref_len_i,
    input  logic [1:0][LINE_W-1:0]       vs_line_i,
    input  logic [1:0][PIX_W-1:0]        vs_pix_i,
    input  logic [1:0][SPAN_W-1:0]       vs_len_i,
    input  logic                         fref_inv_i,
    input  logic                         href_gate_i,
    output logic                         href_o,
    output logic                         vref_o,
    output logic                         fref_o,
    output logic                         hs_o,
    output logic                         vs_o,
    output logic                         de_o
);

    localparam int LW1   = LINE_W + 1;
    localparam int POS_W = LW1 + PIX_W;

    logic [1:0]       vref_hit;
    logic [1:0]       vs_hit;
    logic [POS_W-1:0] pos_now;
    logic             sel;
    logic             href_raw;

    assign pos_now = {1'b0, line_i, pix_i};

    for (genvar f = 0; f < 2; f++) begin : g_fld
        logic [LW1-1:0]   vref_end;
        logic [LW1-1:0]   vs_end_line;
        logic [POS_W-1:0] vs_beg;
        logic [POS_W-1:0] vs_end;

        assign vref_end    = {1'b0, vref_line_i[f]} + LW1'(vref_len_i[f]);
        assign vs_end_line = {1'b0, vs_line_i[f]} + LW1'(vs_len_i[f]);
        assign vs_beg      = {1'b0, vs_line_i[f], vs_pix_i[f]};
        assign vs_end      = {vs_end_line, vs_pix_i[f]};

        assign vref_hit[f] = span_hit(32'({1'b0, line_i}),
                                      32'({1'b0, vref_line_i[f]}),
                                      32'(vref_end));
        assign vs_hit[f]   = span_hit(32'(pos_now), 32'(vs_beg), 32'(vs_end));
    end

    assign sel      = (field_i == FIELD_TWO);
    assign vref_o   = vref_hit[sel];
    assign vs_o     = vs_hit[sel];
    assign href_raw = span_hit(32'(pix_i), 32'(href_start_i), 32'(href_stop_i));
    assign href_o   = href_raw & ~(href_gate_i & vref_o);
    assign de_o     = href_o & ~vref_o;
    assign hs_o     = span_hit(32'(pix_i), 32'(hs_start_i), 32'(hs_stop_i));
    assign fref_o   = sel ^ fref_inv_i;

endmodule

// File: rtl/vidref_timing.sv
module vidref_timing
    import vrt_pkg::*;
#(
    parameter int PIX_W  = DEF_PIX_W,
    parameter int LINE_W = DEF_LINE_W,
    parameter int SPAN_W = DEF_SPAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              interlaced_i,
    input  logic [LINE_W-1:0] line_preset_i,
    input  logic [PIX_W-1:0]  href_start_i,
    input  logic [PIX_W-1:0]  href_stop_i,
    input  logic [PIX_W-1:0]  hs_start_i,
    input  logic [PIX_W-1:0]  hs_stop_i,
    input  logic [LINE_W-1:0] vref1_line_i,
    input  logic [SPAN_W-1:0] vref1_len_i,
    input  logic [LINE_W-1:0] vref2_line_i,
    input  logic [SPAN_W-1:0] vref2_len_i,
    input  logic [LINE_W-1:0] fref1_line_i,
    input  logic [LINE_W-1:0] fref2_line_i,
    input  logic              fref_inv_i,
    input  logic [LINE_W-1:0] vs1_line_i,
    input  logic [PIX_W-1:0]  vs1_pix_i,
    input  logic [SPAN_W-1:0] vs1_len_i,
    input  logic [LINE_W-1:0] vs2_line_i,
    input  logic [PIX_W-1:0]  vs2_pix_i,
    input  logic [SPAN_W-1:0] vs2_len_i,
    input  logic              href_gate_i,
    output logic              href_o,
    output logic              vref_o,
    output logic              fref_o,
    output logic              hs_o,
    output logic              vs_o,
    output logic              de_o
);

    logic [PIX_W-1:0]  pix_w;
    logic [LINE_W-1:0] line_w;
    field_e            field_w;

    vrt_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .hsync_i      (hsync_i),
        .vsync_i      (vsync_i),
        .interlaced_i (interlaced_i),
        .line_preset_i(line_preset_i),
        .pix_o        (pix_w),
        .line_o       (line_w)
    );

    vrt_field #(.LINE_W(LINE_W)) u_fld (
        .clk         (clk),
        .rst         (rst),
        .interlaced_i(interlaced_i),
        .line_i      (line_w),
        .f1_line_i   (fref1_line_i),
        .f2_line_i   (fref2_line_i),
        .field_o     (field_w)
    );

    vrt_decode #(.PIX_W(PIX_W), .LINE_W(LINE_W), .SPAN_W(SPAN_W)) u_dec (
        .pix_i       (pix_w),
        .line_i      (line_w),
        .field_i     (field_w),
        .href_start_i(href_start_i),
        .href_stop_i (href_stop_i),
        .hs_start_i  (hs_start_i),
        .hs_stop_i   (hs_stop_i),
        .vref_line_i ({vref2_line_i, vref1_line_i}),
        .vref_len_i  ({vref2_len_i, vref1_len_i}),
        .vs_line_i   ({vs2_line_i, vs1_line_i}),
        .vs_pix_i    ({vs2_pix_i, vs1_pix_i}),
        .vs_len_i    ({vs2_len_i, vs1_len_i}),
        .fref_inv_i  (fref_inv_i),
        .href_gate_i (href_gate_i),
        .href_o      (href_o),
        .vref_o      (vref_o),
        .fref_o      (fref_o),
        .hs_o        (hs_o),
        .vs_o        (vs_o),
        .de_o        (de_o)
    );

endmodule

// File: rtl/vidref_timing_chk.sv
module vidref_timing_chk #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              hsync_i,
    input logic              vsync_i,
    input logic              interlaced_i,
    input logic [LINE_W-1:0] line_preset_i,
    input logic              fref_inv_i,
    input logic              href_gate_i,
    input logic              href_o,
    input logic              vref_o,
    input logic              fref_o,
    input logic [PIX_W-1:0]  pix,
    input logic [LINE_W-1:0] line
);

    // R2
    pix_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (hsync_i && !$past(hsync_i)) |=> (pix == '0));

    // R2
    pix_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !(hsync_i && !$past(hsync_i)) |=> (pix == PIX_W'($past(pix) + 1'b1)));

    // R3
    line_preset_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync_i && !$past(vsync_i) && !interlaced_i) |=> (line == $past(line_preset_i)));

    // R7
    field_prog_chk: assert property (@(posedge clk) disable iff (rst)
        !interlaced_i |=> (fref_o == fref_inv_i));

    // R10
    href_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (href_gate_i && vref_o) |-> !href_o);

endmodule

bind vidref_timing vidref_timing_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hsync_i      (hsync_i),
    .vsync_i      (vsync_i),
    .interlaced_i (interlaced_i),
    .line_preset_i(line_preset_i),
    .fref_inv_i   (fref_inv_i),
    .href_gate_i  (href_gate_i),
    .href_o       (href_o),
    .vref_o       (vref_o),
    .fref_o       (fref_o),
    .pix          (pix_w),
    .line         (line_w)
);

// File: tb/sim_vidref_timing.sv
`timescale 1ns/1ps
module sim_vidref_timing;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync = 1'b0, vsync = 1'b0, ilace = 1'b0;
    logic [10:0] preset = '0;
    logic [11:0] hr_s = '0, hr_e = '0, hs_s = '0, hs_e = '0;
    logic [10:0] v1l = '0, v2l = '0, f1l = '0, f2l = '0, s1l = '0, s2l = '0;
    logic [7:0]  v1n = '0, v2n = '0, s1n = '0, s2n = '0;
    logic [11:0] s1p = '0, s2p = '0;
    logic finv = 1'b0, gate = 1'b0;
    logic href, vref, fref, hso, vso, de;

    int checks = 0, fails = 0;
    bit done = 0;
    string tag = "R1";

    always #2 clk = ~clk;  // 250 MHz

    vidref_timing u0 (
        .clk(clk), .rst(rst), .hsync_i(hsync), .vsync_i(vsync), .interlaced_i(ilace),
        .line_preset_i(preset), .href_start_i(hr_s), .href_stop_i(hr_e),
        .hs_start_i(hs_s), .hs_stop_i(hs_e),
        .vref1_line_i(v1l), .vref1_len_i(v1n), .vref2_line_i(v2l), .vref2_len_i(v2n),
        .fref1_line_i(f1l), .fref2_line_i(f2l), .fref_inv_i(finv),
        .vs1_line_i(s1l), .vs1_pix_i(s1p), .vs1_len_i(s1n),
        .vs2_line_i(s2l), .vs2_pix_i(s2p), .vs2_len_i(s2n),
        .href_gate_i(gate),
        .href_o(href), .vref_o(vref), .fref_o(fref), .hs_o(hso), .vs_o(vso), .de_o(de)
    );

    // behavioural reference model
    int m_pix = 0, m_line = 0, m_skip = 0, m_f2 = 0;
    int hs_prev = 0, vs_prev = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_pix = 0; m_line = 0; m_skip = 0; m_f2 = 0;
        end else begin
            int hr, vr, take;
            hr = (hsync && !hs_prev) ? 1 : 0;
            vr = (vsync && !vs_prev) ? 1 : 0;
            if (!ilace) m_f2 = 0;
            else if (m_line == f2l) m_f2 = 1;
            else if (m_line == f1l) m_f2 = 0;
            take = (vr && (!ilace || m_skip == 0)) ? 1 : 0;
            if (vr) m_skip = ilace ? 1 - m_skip : 0;
            m_pix = hr ? 0 : (m_pix + 1) % 4096;
            if (take) m_line = preset;
            else if (hr) m_line = (m_line + 1) % 2048;
        end
        hs_prev = hsync;
        vs_prev = vsync;
    end

    task automatic chk(input string req, input string nm, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL [%s] %s %s: got %b expected %b (pix %0d line %0d)",
                     tag, req, nm, got, exp, m_pix, m_line);
        end
    endtask

    task automatic check_all();
        int vl, vn, sl, sp, sn, pos;
        logic e_vref, e_href, e_vs;
        vl = m_f2 ? v2l : v1l;  vn = m_f2 ? v2n : v1n;
        sl = m_f2 ? s2l : s1l;  sp = m_f2 ? s2p : s1p;  sn = m_f2 ? s2n : s1n;
        e_vref = (m_line >= vl) && (m_line < vl + vn);
        pos = m_line * 4096 + m_pix;
        e_vs = (pos >= sl * 4096 + sp) && (pos < (sl + sn) * 4096 + sp);
        e_href = (m_pix >= hr_s) && (m_pix < hr_e) && !(gate && e_vref);
        chk("R6", "vref", vref, e_vref);
        chk("R5/R10", "href", href, e_href);
        chk("R11", "de", de, e_href && !e_vref);
        chk("R9", "hs", hso, (m_pix >= hs_s) && (m_pix < hs_e));
        chk("R8", "vs", vso, e_vs);
        chk("R7", "fref", fref, logic'(m_f2) ^ finv);
    endtask

    bit started = 0;
    always @(negedge clk) begin
        #1;
        if (started && !done) check_all();
    end

    task automatic run_line(input int len, input bit vs_on);
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            hsync = (c < 4);
            vsync = vs_on;
        end
    endtask

    task automatic run_frame(input int nl, input int len, input int va, input int vb);
        for (int l = 0; l < nl; l++)
            run_line(len, ((l >= va) && (l < va + 2)) || ((l >= vb) && (l < vb + 2)));
    endtask

    task automatic base_cfg();
        @(negedge clk);
        preset = 11'd1; hr_s = 12'd8; hr_e = 12'd32; hs_s = 12'd0; hs_e = 12'd3;
        v1l = 11'd1; v1n = 8'd4; v2l = 11'd0; v2n = 8'd0;
        f1l = 11'd1; f2l = 11'd16;
        s1l = 11'd2; s1p = 12'd10; s1n = 8'd2;
        s2l = 11'd17; s2p = 12'd20; s2n = 8'd2;
        finv = 1'b0; gate = 1'b0; ilace = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        base_cfg();
        started = 1;
        // R1: reset state, with inverted field flag
        tag = "R1";
        finv = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk("R1", "fref_reset", fref, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        finv = 1'b0;

        // progressive frames, preload coincident with hsync edge
        tag = "R3";
        for (int f = 0; f < 3; f++) run_frame(25, 40, 0, -10);

        // blanking gate on active window
        tag = "R10";
        gate = 1'b1;
        for (int f = 0; f < 2; f++) run_frame(25, 40, 0, -10);

        // interlaced: second vsync of each frame ignored
        tag = "R4";
        ilace = 1'b1; finv = 1'b1;
        v2l = 11'd16; v2n = 8'd3;
        for (int f = 0; f < 4; f++) run_frame(30, 40, 0, 15);

        // back to progressive, then line wrap from a high preset
        tag = "R3";
        ilace = 1'b0; finv = 1'b0; gate = 1'b0;
        v2l = '0; v2n = '0;
        preset = 11'd2040; v1l = 11'd2045; v1n = 8'd10;
        run_frame(15, 40, 0, -10);

        // pixel count wrap in one long line
        tag = "R2";
        hr_s = 12'd4090; hr_e = 12'd4095; hs_s = 12'd5; hs_e = 12'd9;
        run_line(4300, 1'b0);
        run_line(40, 1'b0);

        // reset in mid-frame
        tag = "R1";
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "fref_reset", fref, finv);
        @(negedge clk); rst = 1'b0;
        tag = "R3";
        run_frame(6, 40, 0, -10);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule